// File: doc/BRIEF.md
# TLB-Backed Page Address Translator

This block turns a 16-bit virtual address into a 15-bit physical address for a small paged memory. The upper six bits of the virtual address select a page, and the lower ten bits are the byte offset inside a 1024-byte page. The offset is carried through untouched. A four-entry fully associative translation buffer holds recent page-to-frame pairs, so a repeated access to the same page is answered without touching memory.

When the buffer does not hold the page, the block walks the page table itself. It reads one entry from a memory port at a base address plus the page number, then tests the resident flag. A page that is not resident ends the request with a one-cycle fault pulse. A resident page is installed in the buffer and the request completes. While it does this, the block keeps the reference and dirty flags of the entry up to date by writing the entry back when either flag has to change. Requests arrive on a valid/ready handshake, and each one ends with exactly one response pulse or one fault pulse.

Top module: `paged_xlate`

## Requirements
- R1: While reset is applied and after it is released, with no request pending, `req_ready` is 1 and `rsp_valid`, `page_fault`, `mem_rd` and `mem_wr` are 0.
- R2: The physical address of a response is the 5-bit frame number in bits [14:10] followed by bits [9:0] of the virtual address, unchanged.
- R3: A read to a page held in the buffer is answered with `rsp_valid` one cycle after the request is accepted, with no memory read or write.
- R4: On a miss the block reads the page-table entry at address `pt_base` + page number (page number = `req_vaddr[15:10]`). Its layout is frame in bits [4:0], reference flag in bit 5, resident flag in bit 6 and dirty flag in bit 7. The response to a resident miss comes three cycles after acceptance.
- R5: A resident entry fetched on a miss is installed, so a later access to the same page hits without a memory access.
- R6: A fetched entry with resident flag 0 gives a `page_fault` pulse of one cycle and no `rsp_valid`. Nothing is installed, so the next access walks again, and the entry in memory is not written.
- R7: On a read miss, the entry is written back with the reference flag set only if that flag was 0. The dirty flag is left as it was.
- R8: A write access to a page whose entry is not yet dirty writes the entry back with the dirty, reference and resident flags set. This holds on a miss, and also on a hit to a clean buffer entry, which then responds two cycles after acceptance. Later writes to that page hit with no memory access.
- R9: The buffer holds 4 entries filled in round-robin order, and the pointer advances only on an install. The fifth distinct page installed replaces the first one.
- R10: A one-cycle pulse on `flush` invalidates every buffer entry, so the next access to any page walks the table.
- R11: `req_ready` is 0 while a miss or a dirty-marking write is in progress, and `rsp_valid` and `page_fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all translation buffer entries |
| pt_base | input | 16 | Page-table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 16 | Virtual address of the request |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_paddr` is valid |
| rsp_paddr | output | 15 | Translated physical address |
| page_fault | output | 1 | One-cycle strobe: page not resident |
| mem_rd | output | 1 | Page-table entry read strobe |
| mem_wr | output | 1 | Page-table entry write strobe |
| mem_addr | output | 16 | Page-table entry address |
| mem_wdata | output | 8 | Page-table entry write data |
| mem_rdata | input | 8 | Page-table entry read data, valid the cycle after `mem_rd` |

## Verification
The assertions assume that the memory returns `mem_rdata` exactly one cycle after `mem_rd`, and that `pt_base` does not change while a walk is in progress. They also assume that `flush` is never raised in the same cycle a request is accepted, and that `req_valid` is only held while `req_ready` is high. The stimulus meets these conditions. Its memory model answers every read on the following edge, the base address is set once before the first request, and each request is raised for a single accepting edge. Flush pulses are placed only between requests, once the previous response has been seen.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   // Walker states. The order is free: no neighbour decodes the encoding.
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FETCH = 2'd1,
      ST_CHECK = 2'd2,
      ST_MARK  = 2'd3
   } walk_st_e;

endpackage

// File: rtl/xlate_pte_upd.sv
// Decodes a fetched page-table entry and works out the flags it must carry
// after this access. Flag positions sit just above the frame field.
module xlate_pte_upd #(
   parameter int FRAME_W = 5
) (
   input  logic [FRAME_W+2:0] pte_in,
   input  logic               acc_write,
   output logic [FRAME_W-1:0] frame_o,
   output logic               resident_o,
   output logic               dirty_o,
   output logic               need_wb_o,
   output logic [FRAME_W+2:0] pte_o
);
   localparam int REF_B = FRAME_W;
   localparam int RES_B = FRAME_W + 1;
   localparam int DRT_B = FRAME_W + 2;

   logic ref_old, dirty_old;

   always_comb begin
      frame_o    = pte_in[FRAME_W-1:0];
      resident_o = pte_in[RES_B];
      ref_old    = pte_in[REF_B];
      dirty_old  = pte_in[DRT_B];
      dirty_o    = dirty_old | acc_write;
      need_wb_o  = ~ref_old | (acc_write & ~dirty_old);
      pte_o               = pte_in;
      pte_o[REF_B]        = 1'b1;
      pte_o[DRT_B]        = dirty_o;
   end
endmodule

// File: rtl/xlate_tlb.sv
// Fully associative translation buffer with round-robin fill.
module xlate_tlb #(
   parameter int TAG_W   = 6,
   parameter int FRAME_W = 5,
   parameter int ENTRIES = 4,
   parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [TAG_W-1:0]   lk_tag,
   output logic               lk_hit,
   output logic [FRAME_W-1:0] lk_frame,
   output logic               lk_dirty,
   output logic [IDX_W-1:0]   lk_idx,
   input  logic               ins_en,
   input  logic [TAG_W-1:0]   ins_tag,
   input  logic [FRAME_W-1:0] ins_frame,
   input  logic               ins_dirty,
   input  logic               mark_en,
   input  logic [IDX_W-1:0]   mark_idx,
   output logic [ENTRIES-1:0] match_vec,
   output logic [ENTRIES-1:0] valid_vec
);
   localparam int LAST = ENTRIES - 1;

   logic [IDX_W-1:0]   rr_q, rr_nxt;
   logic [FRAME_W-1:0] frame_arr [ENTRIES];
   logic [ENTRIES-1:0] dirty_vec;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic               v_q, d_q;
      logic [TAG_W-1:0]   t_q;
      logic [FRAME_W-1:0] f_q;
      logic               sel_ins, sel_mark;

      assign sel_ins  = ins_en  && (rr_q == IDX_W'(i));
      assign sel_mark = mark_en && (mark_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= 1'b0;
            t_q <= '0;
            f_q <= '0;
         end else if (flush) begin
            v_q <= 1'b0;
         end else if (sel_ins) begin
            v_q <= 1'b1;
            d_q <= ins_dirty;
            t_q <= ins_tag;
            f_q <= ins_frame;
         end else if (sel_mark) begin
            d_q <= 1'b1;
         end
      end

      assign valid_vec[i] = v_q;
      assign dirty_vec[i] = d_q;
      assign frame_arr[i] = f_q;
      assign match_vec[i] = v_q && (t_q == lk_tag);
   end

   always_comb begin
      lk_hit   = |match_vec;
      lk_frame = '0;
      lk_dirty = 1'b0;
      lk_idx   = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         lk_frame = lk_frame | ({FRAME_W{match_vec[i]}} & frame_arr[i]);
         lk_dirty = lk_dirty | (match_vec[i] & dirty_vec[i]);
         lk_idx   = lk_idx   | (match_vec[i] ? IDX_W'(i) : '0);
      end
   end

   // Replacement pointer: the variant depends on the entry count.
   if (ENTRIES == 1) begin : g_rr_single
      assign rr_nxt = '0;
   end else if ((ENTRIES & (ENTRIES - 1)) == 0) begin : g_rr_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_rr_wrap
      assign rr_nxt = (rr_q == IDX_W'(LAST)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rr_q <= '0;
      else if (ins_en) rr_q <= rr_nxt;
   end
endmodule

// File: rtl/xlate_walk.sv
// Request sequencer: hit response, page-table fetch, fault and flag update.
module xlate_walk
   import xlate_pkg::*;
#(
   parameter int VA_W    = 16,
   parameter int OFF_W   = 10,
   parameter int FRAME_W = 5,
   parameter int MA_W    = 16,
   parameter int IDX_W   = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [MA_W-1:0]          pt_base,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic                     req_write,
   output logic                     rsp_valid,
   output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
   output logic                     page_fault,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic [MA_W-1:0]          mem_addr,
   output logic [FRAME_W+2:0]       mem_wdata,
   input  logic [FRAME_W+2:0]       mem_rdata,
   input  logic                     lk_hit,
   input  logic [FRAME_W-1:0]       lk_frame,
   input  logic                     lk_dirty,
   input  logic [IDX_W-1:0]         lk_idx,
   output logic                     ins_en,
   output logic [VA_W-OFF_W-1:0]    ins_tag,
   output logic [FRAME_W-1:0]       ins_frame,
   output logic                     ins_dirty,
   output logic                     mark_en,
   output logic [IDX_W-1:0]         mark_idx
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int PA_W  = FRAME_W + OFF_W;
   localparam int PTE_W = FRAME_W + 3;
   localparam int REF_B = FRAME_W;
   localparam int RES_B = FRAME_W + 1;
   localparam int DRT_B = FRAME_W + 2;

   walk_st_e           st_q;
   logic [VPN_W-1:0]   vpn_q;
   logic [OFF_W-1:0]   off_q;
   logic               wr_q;
   logic [FRAME_W-1:0] frame_q;
   logic [IDX_W-1:0]   idx_q;
   logic               rsp_q, flt_q;
   logic [PA_W-1:0]    pa_q;

   logic [FRAME_W-1:0] u_frame;
   logic               u_res, u_dirty, u_wb;
   logic [PTE_W-1:0]   u_pte, mark_pte;

   xlate_pte_upd #(.FRAME_W(FRAME_W)) u_upd (
      .pte_in     (mem_rdata),
      .acc_write  (wr_q),
      .frame_o    (u_frame),
      .resident_o (u_res),
      .dirty_o    (u_dirty),
      .need_wb_o  (u_wb),
      .pte_o      (u_pte)
   );

   always_comb begin
      mark_pte                 = '0;
      mark_pte[FRAME_W-1:0]    = frame_q;
      mark_pte[REF_B]          = 1'b1;
      mark_pte[RES_B]          = 1'b1;
      mark_pte[DRT_B]          = 1'b1;

      req_ready = (st_q == ST_IDLE);
      mem_rd    = (st_q == ST_FETCH);
      mem_wr    = ((st_q == ST_CHECK) && u_res && u_wb) || (st_q == ST_MARK);
      mem_addr  = pt_base + MA_W'(vpn_q);
      mem_wdata = (st_q == ST_MARK) ? mark_pte : u_pte;
      ins_en    = (st_q == ST_CHECK) && u_res;
      ins_tag   = vpn_q;
      ins_frame = u_frame;
      ins_dirty = u_dirty;
      mark_en   = (st_q == ST_MARK);
      mark_idx  = idx_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         vpn_q   <= '0;
         off_q   <= '0;
         wr_q    <= 1'b0;
         frame_q <= '0;
         idx_q   <= '0;
         rsp_q   <= 1'b0;
         flt_q   <= 1'b0;
         pa_q    <= '0;
      end else begin
         rsp_q <= 1'b0;
         flt_q <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  vpn_q <= req_vaddr[VA_W-1:OFF_W];
                  off_q <= req_vaddr[OFF_W-1:0];
                  wr_q  <= req_write;
                  if (lk_hit) begin
                     if (req_write && !lk_dirty) begin
                        st_q    <= ST_MARK;
                        frame_q <= lk_frame;
                        idx_q   <= lk_idx;
                     end else begin
                        rsp_q <= 1'b1;
                        pa_q  <= {lk_frame, req_vaddr[OFF_W-1:0]};
                     end
                  end else begin
                     st_q <= ST_FETCH;
                  end
               end
            end
            ST_FETCH: st_q <= ST_CHECK;
            ST_CHECK: begin
               if (u_res) begin
                  rsp_q <= 1'b1;
                  pa_q  <= {u_frame, off_q};
               end else begin
                  flt_q <= 1'b1;
               end
               st_q <= ST_IDLE;
            end
            ST_MARK: begin
               rsp_q <= 1'b1;
               pa_q  <= {frame_q, off_q};
               st_q  <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign rsp_valid  = rsp_q;
   assign rsp_paddr  = pa_q;
   assign page_fault = flt_q;
endmodule

// File: rtl/paged_xlate.sv
module paged_xlate #(
   parameter int VA_W    = 16,
   parameter int OFF_W   = 10,
   parameter int FRAME_W = 5,
   parameter int TLB_N   = 4,
   parameter int MA_W    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [MA_W-1:0]          pt_base,
   input  logic                     req_valid,
   output logic                     req_ready,
   input  logic [VA_W-1:0]          req_vaddr,
   input  logic                     req_write,
   output logic                     rsp_valid,
   output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
   output logic                     page_fault,
   output logic                     mem_rd,
   output logic                     mem_wr,
   output logic [MA_W-1:0]          mem_addr,
   output logic [FRAME_W+2:0]       mem_wdata,
   input  logic [FRAME_W+2:0]       mem_rdata
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

   if (OFF_W < 1 || VPN_W < 1) begin : g_bad_split
      $error("paged_xlate: virtual address must hold both a page number and an offset");
   end
   if (FRAME_W < 1) begin : g_bad_frame
      $error("paged_xlate: frame width must be at least 1");
   end
   if (TLB_N < 1) begin : g_bad_depth
      $error("paged_xlate: buffer needs at least one entry");
   end
   if (VPN_W > MA_W) begin : g_bad_ma
      $error("paged_xlate: page number wider than the table address");
   end

   logic               tlb_hit, tlb_dirty;
   logic [FRAME_W-1:0] tlb_frame;
   logic [IDX_W-1:0]   tlb_idx;
   logic [TLB_N-1:0]   tlb_match, tlb_valid;
   logic               ins_en, ins_dirty, mark_en;
   logic [VPN_W-1:0]   ins_tag;
   logic [FRAME_W-1:0] ins_frame;
   logic [IDX_W-1:0]   mark_idx;

   xlate_tlb #(
      .TAG_W   (VPN_W),
      .FRAME_W (FRAME_W),
      .ENTRIES (TLB_N),
      .IDX_W   (IDX_W)
   ) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .lk_tag    (req_vaddr[VA_W-1:OFF_W]),
      .lk_hit    (tlb_hit),
      .lk_frame  (tlb_frame),
      .lk_dirty  (tlb_dirty),
      .lk_idx    (tlb_idx),
      .ins_en    (ins_en),
      .ins_tag   (ins_tag),
      .ins_frame (ins_frame),
      .ins_dirty (ins_dirty),
      .mark_en   (mark_en),
      .mark_idx  (mark_idx),
      .match_vec (tlb_match),
      .valid_vec (tlb_valid)
   );

   xlate_walk #(
      .VA_W    (VA_W),
      .OFF_W   (OFF_W),
      .FRAME_W (FRAME_W),
      .MA_W    (MA_W),
      .IDX_W   (IDX_W)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .pt_base    (pt_base),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_vaddr  (req_vaddr),
      .req_write  (req_write),
      .rsp_valid  (rsp_valid),
      .rsp_paddr  (rsp_paddr),
      .page_fault (page_fault),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .lk_hit     (tlb_hit),
      .lk_frame   (tlb_frame),
      .lk_dirty   (tlb_dirty),
      .lk_idx     (tlb_idx),
      .ins_en     (ins_en),
      .ins_tag    (ins_tag),
      .ins_frame  (ins_frame),
      .ins_dirty  (ins_dirty),
      .mark_en    (mark_en),
      .mark_idx   (mark_idx)
   );
endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
   parameter int OFF_W = 10,
   parameter int TLB_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             req_valid,
   input logic             req_ready,
   input logic             req_write,
   input logic [OFF_W-1:0] req_off,
   input logic             rsp_valid,
   input logic [OFF_W-1:0] rsp_off,
   input logic             page_fault,
   input logic             mem_rd,
   input logic             mem_wr,
   input logic             lk_hit,
   input logic [TLB_N-1:0] match_vec,
   input logic [TLB_N-1:0] valid_vec
);
   logic [OFF_W-1:0] off_cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      off_cap <= '0;
      else if (req_valid && req_ready) off_cap <= req_off;
   end

   p_offset_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_off == off_cap);

   p_hit_quick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && lk_hit && !req_write)
         |=> (rsp_valid && !mem_rd && !mem_wr));

   p_single_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);

   p_unique_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      page_fault |=> !page_fault);

   p_fault_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      page_fault |-> !$past(mem_wr));

   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_vec == '0));

   p_resp_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && page_fault));

   p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> !req_ready);
endmodule

bind paged_xlate xlate_chk #(
   .OFF_W (OFF_W),
   .TLB_N (TLB_N)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flush      (flush),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_write  (req_write),
   .req_off    (req_vaddr[OFF_W-1:0]),
   .rsp_valid  (rsp_valid),
   .rsp_off    (rsp_paddr[OFF_W-1:0]),
   .page_fault (page_fault),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .lk_hit     (tlb_hit),
   .match_vec  (tlb_match),
   .valid_vec  (tlb_valid)
);

// File: tb/sim_paged_xlate.sv
`timescale 1ns/1ps
module sim_paged_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [15:0] pt_base = 16'h0040;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_vaddr = '0;
   logic        req_write = 1'b0;
   logic        rsp_valid;
   logic [14:0] rsp_paddr;
   logic        page_fault;
   logic        mem_rd, mem_wr;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   int tests = 0;
   int fails = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   paged_xlate u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .page_fault(page_fault), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   // Page p: frame (7p+3) mod 32, resident unless p mod 5 == 4, flags clear.
   function automatic logic [4:0] frame_of(input int p);
      return 5'((p * 7 + 3) % 32);
   endfunction

   logic [7:0] pt_mem [256];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            if (i >= 64 && i < 128)
               pt_mem[i] <= {1'b0, ((i - 64) % 5 != 4), 1'b0, frame_of(i - 64)};
            else
               pt_mem[i] <= 8'h00;
         end
         mem_rdata <= 8'h00;
      end else begin
         if (mem_rd) mem_rdata <= pt_mem[mem_addr[7:0]];
         if (mem_wr) pt_mem[mem_addr[7:0]] <= mem_wdata;
      end
   end

   always @(negedge clk) begin
      if (mem_rd) rd_cnt++;
      if (mem_wr) wr_cnt++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_req(input logic [15:0] va, input logic wr,
                          output logic [14:0] pa, output logic flt,
                          output int lat, output int rds, output int wrs,
                          output bit busy_ok);
      @(negedge clk);
      req_vaddr = va;
      req_write = wr;
      req_valid = 1'b1;
      rd_cnt = 0;
      wr_cnt = 0;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      busy_ok = 1'b1;
      while (!(rsp_valid || page_fault) && lat < 40) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      pa  = rsp_paddr;
      flt = page_fault;
      rds = rd_cnt;
      wrs = wr_cnt;
   endtask

   // Fields: vaddr[19:4], write[3], fault[2], walk read[1], entry write-back[0]
   localparam logic [19:0] VEC [16] = '{
      {16'h0455, 1'b0, 1'b0, 1'b1, 1'b1},  // p1 read miss, ref set
      {16'h07FF, 1'b0, 1'b0, 1'b0, 1'b0},  // p1 read hit
      {16'h0801, 1'b1, 1'b0, 1'b1, 1'b1},  // p2 write miss, dirty set
      {16'h0A00, 1'b1, 1'b0, 1'b0, 1'b0},  // p2 write hit, already dirty
      {16'h1010, 1'b0, 1'b1, 1'b1, 1'b0},  // p4 not resident
      {16'h1011, 1'b1, 1'b1, 1'b1, 1'b0},  // p4 again: not installed
      {16'h0523, 1'b1, 1'b0, 1'b0, 1'b1},  // p1 write hit on clean entry
      {16'h0C00, 1'b0, 1'b0, 1'b1, 1'b1},  // p3 miss
      {16'h17FE, 1'b0, 1'b0, 1'b1, 1'b1},  // p5 miss, buffer now full
      {16'h1880, 1'b0, 1'b0, 1'b1, 1'b1},  // p6 miss, evicts p1
      {16'h0401, 1'b0, 1'b0, 1'b1, 1'b0},  // p1 walks again, flags set
      {16'h0EAA, 1'b0, 1'b0, 1'b0, 1'b0},  // p3 still held
      {16'h0804, 1'b0, 1'b0, 1'b1, 1'b0},  // p2 evicted earlier
      {16'h0FC3, 1'b0, 1'b0, 1'b1, 1'b0},  // p3 evicted by p2
      {16'h18F0, 1'b1, 1'b0, 1'b0, 1'b1},  // p6 write hit on clean entry
      {16'h0100, 1'b1, 1'b0, 1'b1, 1'b1}   // p0 write miss
   };

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [14:0] pa;
      logic        flt;
      int          lat, rds, wrs, exp_lat;
      bit          busy_ok;

      repeat (3) @(negedge clk);
      // R1 during reset
      chk(req_ready && !rsp_valid && !page_fault && !mem_rd && !mem_wr,
          "R1 outputs in reset", {27'd0, req_ready, rsp_valid, page_fault, mem_rd, mem_wr}, 32'h10);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(req_ready && !rsp_valid && !page_fault && !mem_rd && !mem_wr,
          "R1 outputs after reset", {27'd0, req_ready, rsp_valid, page_fault, mem_rd, mem_wr}, 32'h10);

      for (int v = 0; v < 16; v++) begin
         logic [15:0] va;
         logic        wr, e_flt, e_rd, e_wb;
         logic [14:0] e_pa;
         {va, wr, e_flt, e_rd, e_wb} = VEC[v];
         e_pa = {frame_of(int'(va[15:10])), va[9:0]};
         exp_lat = e_rd ? 3 : (e_wb ? 2 : 1);
         run_req(va, wr, pa, flt, lat, rds, wrs, busy_ok);
         if (e_flt)
            chk(flt === 1'b1, "R6 fault raised", 32'(flt), 32'd1);
         else
            chk(flt === 1'b0 && pa === e_pa, "R2 physical address",
                32'(pa), 32'(e_pa));
         chk(rds == int'(e_rd), e_rd ? "R4 table read on miss" : "R3 R5 hit without read",
             32'(rds), 32'(e_rd));
         chk(wrs == int'(e_wb), e_wr_msg(wr, e_flt), 32'(wrs), 32'(e_wb));
         chk(lat == exp_lat, "R3 R4 R8 response latency", 32'(lat), 32'(exp_lat));
         chk(busy_ok, "R11 not ready while busy", 32'(busy_ok), 32'd1);
      end

      @(negedge clk);
      chk(pt_mem[8'h40] == 8'hE3, "R8 write miss entry", 32'(pt_mem[8'h40]), 32'hE3);
      chk(pt_mem[8'h41] == 8'hEA, "R8 write hit marks entry", 32'(pt_mem[8'h41]), 32'hEA);
      chk(pt_mem[8'h44] == 8'h1F, "R6 faulting entry untouched", 32'(pt_mem[8'h44]), 32'h1F);
      chk(pt_mem[8'h45] == 8'h66, "R7 read sets reference only", 32'(pt_mem[8'h45]), 32'h66);

      // R9: p0 replaced p6 in the slot that held p1; p2, p3 and p0 remain.
      run_req(16'h0807, 1'b0, pa, flt, lat, rds, wrs, busy_ok);
      chk(rds == 0 && lat == 1, "R9 p2 still held", 32'(rds), 32'd0);
      run_req(16'h1881, 1'b0, pa, flt, lat, rds, wrs, busy_ok);
      chk(rds == 1, "R9 p6 replaced round robin", 32'(rds), 32'd1);

      // R10: flush pulse, then a held page must walk again.
      run_req(16'h0102, 1'b0, pa, flt, lat, rds, wrs, busy_ok);
      chk(rds == 0, "R10 p0 held before flush", 32'(rds), 32'd0);
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      run_req(16'h0103, 1'b0, pa, flt, lat, rds, wrs, busy_ok);
      chk(rds == 1 && wrs == 0, "R10 walk after flush", 32'(rds), 32'd1);
      chk(pa == {5'd3, 10'h103}, "R2 R10 address after flush", 32'(pa), 32'h0D03);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   function automatic string e_wr_msg(input logic wr, input logic flt);
      if (flt)     return "R6 no write on fault";
      else if (wr) return "R8 dirty write-back";
      else         return "R7 reference write-back";
   endfunction
endmodule